// File: doc/BRIEF.md
# Downstream Port Containment Unit

This block sits beside a root port or a switch downstream port and isolates the port when an error is serious enough. Two error sources feed it as encoded severities: errors the port detects in itself, and error messages that arrive from the device below. Each source has its own severity threshold. A surprise link-down event can also fire containment, but only when surprise-down reporting is enabled and the legacy hide bit is clear.

Once containment starts, the unit forces the link state machine to the disabled state and stops forwarding host requests. It keeps a table of outstanding non-posted tags. It answers each of those tags with a synthetic completion toward the host, one per cycle, lowest tag first, so the host never waits on a request that can no longer finish. The completion status is Unsupported Request or Completer Abort, chosen by a control bit. Non-posted requests that arrive during containment are answered straight away, and posted ones are dropped. Software ends containment with a write-one-to-clear pulse. That release waits until the tag table is empty.

Top module: `dpc_unit`

## Requirements
- R1: A port error fires containment when `cfg_port_thr_i` is non-zero and `port_err_sev_i >= cfg_port_thr_i`. Severity encoding: 0 none, 1 correctable, 2 non-fatal, 3 fatal. A threshold of 0 disables this source.
- R2: A received error message fires containment under the same rule, using `msg_err_sev_i` and its own threshold `cfg_msg_thr_i`.
- R3: `surprise_down_i` fires containment only when `cfg_sdn_report_i` is 1 and `cfg_sdn_hide_i` is 0.
- R4: `trig_status_o` and `link_disable_o` rise on the clock edge that samples a trigger. While they are high, `req_fwd_o` stays low. Outside containment, `req_fwd_o` follows `req_valid_i` in the same cycle.
- R5: A tag becomes outstanding when a non-posted request is forwarded, and stops being outstanding when `cpl_in_valid_i` returns it outside containment. During containment each outstanding tag gets one synthetic completion, one per cycle in ascending tag order. The first completion appears the cycle after `trig_status_o` rises.
- R6: `syn_cpl_status_o` is 3'b001 (Unsupported Request) when `cfg_ca_i` was 0 in the issuing cycle, and 3'b100 (Completer Abort) when it was 1.
- R7: During containment, a non-posted request (`req_np_i`=1) is completed on the next cycle with its own tag. This takes priority over the drain, which pauses for that cycle. A posted request produces no completion.
- R8: During containment, `cpl_in_valid_i` is ignored, so a returned tag is still drained.
- R9: A `sw_clr_i` pulse during containment is held until the tag table is empty. `trig_status_o` falls on the edge after the first cycle in which both hold.
- R10: With `cfg_en_i` at 0 no trigger fires, and a trigger during containment has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Containment enable |
| cfg_port_thr_i | input | 2 | Severity threshold for port errors (0 = off) |
| cfg_msg_thr_i | input | 2 | Severity threshold for received error messages (0 = off) |
| cfg_sdn_report_i | input | 1 | Surprise-down reporting enabled |
| cfg_sdn_hide_i | input | 1 | Legacy surprise-down hide |
| cfg_ca_i | input | 1 | Synthetic status select: 0 UR, 1 CA |
| port_err_sev_i | input | 2 | Severity of an error detected in the port |
| msg_err_sev_i | input | 2 | Severity of an error message from below |
| surprise_down_i | input | 1 | Surprise link-down event |
| req_valid_i | input | 1 | Host request present |
| req_np_i | input | 1 | Request is non-posted |
| req_tag_i | input | TAG_W | Request tag |
| cpl_in_valid_i | input | 1 | Completion returned by the device |
| cpl_in_tag_i | input | TAG_W | Tag of the returned completion |
| sw_clr_i | input | 1 | Write-one-to-clear pulse for the trigger status |
| req_fwd_o | output | 1 | Request forwarded down the port |
| link_disable_o | output | 1 | Force the link state machine to the disabled state |
| trig_status_o | output | 1 | Sticky containment status |
| syn_cpl_valid_o | output | 1 | Synthetic completion valid |
| syn_cpl_tag_o | output | TAG_W | Synthetic completion tag |
| syn_cpl_status_o | output | 3 | Synthetic completion status |

## Verification
The drain of the tag table and the immediate answer to a fresh non-posted request share one completion channel. Both can want that channel in the same cycle. The bench provokes this by sending a non-posted request, together with a device completion for a still-pending tag, in the middle of a sixteen-tag drain. The cycle-level model expects the fresh tag on the next cycle, then the drain resuming at the next lowest tag, including the tag whose completion was ignored. A second overlap is a software clear that lands while tags remain. The model holds containment until the table is empty and compares the release edge on every clock.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    SEV_NONE     = 2'd0,
    SEV_COR      = 2'd1,
    SEV_NONFATAL = 2'd2,
    SEV_FATAL    = 2'd3
  } sev_e;

  localparam logic [2:0] CPL_UR = 3'b001;
  localparam logic [2:0] CPL_CA = 3'b100;

  function automatic logic sev_hit(logic [1:0] sev, logic [1:0] thr);
    return (thr != 2'd0) && (sev >= thr);
  endfunction
endpackage

// File: rtl/dpc_trigger.sv
module dpc_trigger
  import dpc_pkg::*;
(
  input  logic       cfg_en_i,
  input  logic [1:0] cfg_port_thr_i,
  input  logic [1:0] cfg_msg_thr_i,
  input  logic       cfg_sdn_report_i,
  input  logic       cfg_sdn_hide_i,
  input  logic [1:0] port_err_sev_i,
  input  logic [1:0] msg_err_sev_i,
  input  logic       surprise_down_i,
  output logic       hit_o
);
  logic port_hit, msg_hit, sdn_hit;

  always_comb begin
    port_hit = sev_hit(port_err_sev_i, cfg_port_thr_i);
    msg_hit  = sev_hit(msg_err_sev_i, cfg_msg_thr_i);
    // hide bit masks surprise-down even when reporting is on
    sdn_hit  = surprise_down_i & cfg_sdn_report_i & ~cfg_sdn_hide_i;
    hit_o    = cfg_en_i & (port_hit | msg_hit | sdn_hit);
  end
endmodule

// File: rtl/dpc_tag_table.sv
module dpc_tag_table #(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_en_i,
  input  logic [TAG_W-1:0] clr_tag_i,
  input  logic             pop_en_i,
  output logic             any_o,
  output logic [TAG_W-1:0] low_tag_o
);
  localparam int NTAGS = 1 << TAG_W;

  logic [NTAGS-1:0] pend;

  always_comb begin
    low_tag_o = '0;
    for (int i = NTAGS - 1; i >= 0; i--) begin
      if (pend[i]) low_tag_o = TAG_W'(i);
    end
  end

  assign any_o = |pend;

  for (genvar g = 0; g < NTAGS; g++) begin : g_slot
    logic hit_set, hit_clr, hit_pop;
    assign hit_set = set_en_i & (set_tag_i == TAG_W'(g));
    assign hit_clr = clr_en_i & (clr_tag_i == TAG_W'(g));
    assign hit_pop = pop_en_i & (low_tag_o == TAG_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend[g] <= 1'b0;
      else         pend[g] <= (pend[g] & ~hit_clr & ~hit_pop) | hit_set;
    end
  end
endmodule

// File: rtl/dpc_cpl_gen.sv
module dpc_cpl_gen
  import dpc_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             imm_en_i,
  input  logic [TAG_W-1:0] imm_tag_i,
  input  logic             drn_en_i,
  input  logic [TAG_W-1:0] drn_tag_i,
  input  logic             use_ca_i,
  output logic             drn_take_o,
  output logic             valid_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [2:0]       status_o
);
  // fresh request wins the channel; drain stalls a cycle
  assign drn_take_o = drn_en_i & ~imm_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      tag_o    <= '0;
      status_o <= CPL_UR;
    end else begin
      valid_o <= imm_en_i | drn_en_i;
      if (imm_en_i)      tag_o <= imm_tag_i;
      else if (drn_en_i) tag_o <= drn_tag_i;
      status_o <= use_ca_i ? CPL_CA : CPL_UR;
    end
  end
endmodule

// File: rtl/dpc_unit.sv
module dpc_unit
  import dpc_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic [1:0]       cfg_port_thr_i,
  input  logic [1:0]       cfg_msg_thr_i,
  input  logic             cfg_sdn_report_i,
  input  logic             cfg_sdn_hide_i,
  input  logic             cfg_ca_i,
  input  logic [1:0]       port_err_sev_i,
  input  logic [1:0]       msg_err_sev_i,
  input  logic             surprise_down_i,
  input  logic             req_valid_i,
  input  logic             req_np_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             cpl_in_valid_i,
  input  logic [TAG_W-1:0] cpl_in_tag_i,
  input  logic             sw_clr_i,
  output logic             req_fwd_o,
  output logic             link_disable_o,
  output logic             trig_status_o,
  output logic             syn_cpl_valid_o,
  output logic [TAG_W-1:0] syn_cpl_tag_o,
  output logic [2:0]       syn_cpl_status_o
);
  logic contain, clr_pend;
  logic hit, trig, release_now;
  logic tbl_any, tbl_empty, drn_take, imm_en;
  logic [TAG_W-1:0] low_tag;

  dpc_trigger u_trig (
    .cfg_en_i         (cfg_en_i),
    .cfg_port_thr_i   (cfg_port_thr_i),
    .cfg_msg_thr_i    (cfg_msg_thr_i),
    .cfg_sdn_report_i (cfg_sdn_report_i),
    .cfg_sdn_hide_i   (cfg_sdn_hide_i),
    .port_err_sev_i   (port_err_sev_i),
    .msg_err_sev_i    (msg_err_sev_i),
    .surprise_down_i  (surprise_down_i),
    .hit_o            (hit)
  );

  assign req_fwd_o = req_valid_i & ~contain;
  assign imm_en    = contain & req_valid_i & req_np_i;

  dpc_tag_table #(.TAG_W(TAG_W)) u_tbl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (req_fwd_o & req_np_i),
    .set_tag_i (req_tag_i),
    .clr_en_i  (cpl_in_valid_i & ~contain),
    .clr_tag_i (cpl_in_tag_i),
    .pop_en_i  (drn_take),
    .any_o     (tbl_any),
    .low_tag_o (low_tag)
  );

  assign tbl_empty = ~tbl_any;

  dpc_cpl_gen #(.TAG_W(TAG_W)) u_cpl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .imm_en_i   (imm_en),
    .imm_tag_i  (req_tag_i),
    .drn_en_i   (contain & tbl_any),
    .drn_tag_i  (low_tag),
    .use_ca_i   (cfg_ca_i),
    .drn_take_o (drn_take),
    .valid_o    (syn_cpl_valid_o),
    .tag_o      (syn_cpl_tag_o),
    .status_o   (syn_cpl_status_o)
  );

  assign trig        = hit & ~contain;
  assign release_now = contain & (clr_pend | sw_clr_i) & tbl_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      contain  <= 1'b0;
      clr_pend <= 1'b0;
    end else if (release_now) begin
      contain  <= 1'b0;
      clr_pend <= 1'b0;
    end else if (trig) begin
      contain  <= 1'b1;
    end else if (contain & sw_clr_i) begin
      clr_pend <= 1'b1;
    end
  end

  assign link_disable_o = contain;
  assign trig_status_o  = contain;
endmodule

// File: rtl/dpc_unit_chk.sv
module dpc_unit_chk
  import dpc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_en_i,
  input logic       cfg_ca_i,
  input logic       trig_status_o,
  input logic       syn_cpl_valid_o,
  input logic [2:0] syn_cpl_status_o,
  input logic       tbl_empty
);
  // R10
  rise_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trig_status_o) |-> $past(cfg_en_i));

  // R5
  cpl_when_contained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_cpl_valid_o |-> $past(trig_status_o));

  // R6
  status_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_cpl_valid_o |-> (syn_cpl_status_o == ($past(cfg_ca_i) ? CPL_CA : CPL_UR)));

  // R9
  release_drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(trig_status_o) |-> $past(tbl_empty));
endmodule

bind dpc_unit dpc_unit_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cfg_en_i         (cfg_en_i),
  .cfg_ca_i         (cfg_ca_i),
  .trig_status_o    (trig_status_o),
  .syn_cpl_valid_o  (syn_cpl_valid_o),
  .syn_cpl_status_o (syn_cpl_status_o),
  .tbl_empty        (tbl_empty)
);

// File: tb/dpc_unit_test.sv
`timescale 1ns/1ps
module dpc_unit_test;
  localparam int TW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_en = 1'b1, cfg_rep = 1'b1, cfg_hide = 1'b0, cfg_ca = 1'b0;
  logic [1:0] cfg_pthr = 2'd2, cfg_mthr = 2'd3, psev = '0, msev = '0;
  logic sdn = 1'b0, rv = 1'b0, rnp = 1'b0, cv = 1'b0, clr = 1'b0;
  logic [TW-1:0] rtag = '0, ctag = '0;
  logic fwd, ldis, tstat, sv;
  logic [TW-1:0] stag;
  logic [2:0] sst;

  always #5 clk = ~clk;

  dpc_unit #(.TAG_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(cfg_en), .cfg_port_thr_i(cfg_pthr),
    .cfg_msg_thr_i(cfg_mthr), .cfg_sdn_report_i(cfg_rep), .cfg_sdn_hide_i(cfg_hide),
    .cfg_ca_i(cfg_ca), .port_err_sev_i(psev), .msg_err_sev_i(msev),
    .surprise_down_i(sdn), .req_valid_i(rv), .req_np_i(rnp), .req_tag_i(rtag),
    .cpl_in_valid_i(cv), .cpl_in_tag_i(ctag), .sw_clr_i(clr), .req_fwd_o(fwd),
    .link_disable_o(ldis), .trig_status_o(tstat), .syn_cpl_valid_o(sv),
    .syn_cpl_tag_o(stag), .syn_cpl_status_o(sst)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit m_on = 0, m_hold = 0, m_v = 0;
  bit m_tab[16];
  int m_tag = 0, m_st = 1;

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic bit lvl_hit(int sev, int thr);
    return thr != 0 && sev >= thr;
  endfunction

  task automatic model_step();
    bit fire, empty0, nxt_on;
    int low;
    fire = cfg_en && (lvl_hit(psev, cfg_pthr) || lvl_hit(msev, cfg_mthr) ||
                      (sdn && cfg_rep && !cfg_hide));
    empty0 = 1;
    low = -1;
    foreach (m_tab[i]) if (m_tab[i]) begin
      empty0 = 0;
      if (low < 0) low = i;
    end
    nxt_on = m_on;
    if (!m_on) begin
      m_v = 0;
      if (cv) m_tab[ctag] = 0;
      if (rv && rnp) m_tab[rtag] = 1;
      if (fire) nxt_on = 1;
    end else begin
      m_st = cfg_ca ? 4 : 1;
      if (rv && rnp) begin m_v = 1; m_tag = rtag; end
      else if (low >= 0) begin m_v = 1; m_tag = low; m_tab[low] = 0; end
      else m_v = 0;
      if ((m_hold || clr) && empty0) begin nxt_on = 0; m_hold = 0; end
      else if (clr) m_hold = 1;
    end
    m_on = nxt_on;
  endtask

  // inputs are set at a negedge by the caller; pulses cleared afterwards
  task automatic cyc();
    #1;
    chk(fwd == (rv && !m_on), "R4 forward", fwd, rv && !m_on);
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(tstat == m_on && ldis == m_on, "R4 status", tstat, m_on);
    chk(sv == m_v, "R5 valid", sv, m_v);
    if (m_v) begin
      chk(stag == TW'(m_tag), "R5 tag", stag, m_tag);
      chk(sst == 3'(m_st), "R6 status", sst, m_st);
    end
    rv = 0; rnp = 0; cv = 0; clr = 0; psev = 0; msev = 0; sdn = 0;
  endtask

  task automatic req(bit np, int t);
    rv = 1; rnp = np; rtag = TW'(t); cyc();
  endtask

  task automatic wait_release();
    for (int i = 0; i < 40 && tstat; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tstat == 0 && sv == 0 && ldis == 0, "R4 reset", tstat, 0);
    rst_ni = 1;

    // tags 5,2,9 pending, posted 7 not tracked, 2 retired
    req(1, 5); req(1, 2); req(1, 9); req(0, 7);
    cv = 1; ctag = 2; cyc();
    psev = 2'd1; cyc();
    chk(tstat == 0, "R1 below threshold", tstat, 0);
    psev = 2'd2; cyc();
    chk(tstat == 1 && ldis == 1, "R1 trigger", tstat, 1);
    cyc();
    chk(sv && stag == 5, "R5 first drain", stag, 5);
    cyc();
    chk(sv && stag == 9, "R5 second drain", stag, 9);
    clr = 1; cyc();
    chk(tstat == 0, "R9 release when empty", tstat, 0);

    // full table, message trigger, fresh request and ignored completion mid-drain
    cfg_ca = 1;
    msev = 2'd2; cyc();
    chk(tstat == 0, "R2 below threshold", tstat, 0);
    for (int t = 15; t >= 0; t--) req(1, t);
    msev = 2'd3; cyc();
    chk(tstat == 1, "R2 trigger", tstat, 1);
    cyc();
    chk(sv && stag == 0 && sst == 3'b100, "R6 abort status", sst, 4);
    rv = 1; rnp = 1; rtag = 4'd3; cv = 1; ctag = 4'd1; psev = 2'd3; cyc();
    chk(sv && stag == 3, "R7 immediate", stag, 3);
    cyc();
    chk(sv && stag == 1, "R8 returned tag still drained", stag, 1);
    req(0, 6);
    clr = 1; cyc();
    chk(tstat == 1, "R9 clear deferred", tstat, 1);
    cfg_ca = 0;
    wait_release();
    chk(tstat == 0, "R9 release after drain", tstat, 0);
    req(1, 4); cv = 1; ctag = 4; cyc();

    // surprise down gating
    sdn = 1; cfg_hide = 1; cyc();
    chk(tstat == 0, "R3 hidden", tstat, 0);
    cfg_hide = 0; cfg_rep = 0; sdn = 1; cyc();
    chk(tstat == 0, "R3 not reported", tstat, 0);
    cfg_rep = 1; sdn = 1; cyc();
    chk(tstat == 1, "R3 trigger", tstat, 1);
    clr = 1; cyc();
    chk(tstat == 0, "R9 empty table release", tstat, 0);

    // disabled unit
    cfg_en = 0; psev = 2'd3; msev = 2'd3; sdn = 1; cyc();
    chk(tstat == 0, "R10 disabled", tstat, 0);
    cfg_en = 1;
    req(1, 8); cyc();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule